// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a small SPI master driven by a host through an eight-byte register window. The host first loads an opcode, two low address bytes and up to four data bytes. It then writes a mode byte. The upper nibble of the mode byte picks one of eleven fixed frame shapes. The lower nibble carries address bits 19:16. That single write launches one complete SPI frame. Chip select stays asserted across every byte of the frame.

The frame shapes are:
- an opcode alone;
- an opcode with one write byte;
- an opcode followed by two read bytes;
- an opcode followed by a 20-bit address, then zero, one or four write bytes, or one to four read bytes.

One shape sends a single 0x00 filler byte between the address and a four-byte read. Bytes returned during a frame land in the data registers, where the host can read them once the status bit at offset 1 drops.

The register interface is plain: one write strobe per byte, and a combinational read port. There is no back-pressure. Writes that arrive while a frame runs are simply dropped.

Top module: `sfc_engine`

## Requirements
- R1: After reset every offset reads 0x00, chip select is high and SCLK is low. Offsets 0, 2, 3 and 4..7 read back the last byte written there. Offset 1 reads {7'b0, busy}.
- R2: Writing offset 1 while idle starts a frame. The byte's bits 7:4 are the mode code, valid for codes 1 to 11. Bits 3:0 are address bits 19:16.
- R3: A mode write with code 0 or a code from 12 to 15 starts no frame and changes no register.
- R4: Code 1 sends only the opcode. Code 2 sends the opcode and one write byte. Code 3 sends the opcode and then clocks two read bytes.
- R5: Codes 4, 5, 6, 8, 9, 10 and 11 send the opcode, then the address bytes {4'h0, bits 3:0}, offset 2, offset 3. After the address they send: nothing (4), one write byte (5), four write bytes (6), or read 1, 2, 3 or 4 bytes (8 to 11).
- R6: Code 7 sends the opcode and the three address bytes, then one filler byte of 0x00, then reads four bytes. The byte received during the filler is not stored.
- R7: Write bytes come from offset 4 upward. During read bytes MOSI carries 0x00.
- R8: Read bytes are stored from offset 4 upward in arrival order. Data registers beyond the read count keep their contents.
- R9: The SPI link runs in mode 0, most significant bit first, in whole bytes. Chip select is low across the whole frame, and SCLK is low whenever chip select is high.
- R10: Busy is set from the start of a frame until its end. Every host write received while busy is discarded.
- R11: A frame ends within 1250 system clocks (10 us at 125 MHz) of the mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write offset |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 3 | Host read offset |
| rd_data | output | 8 | Byte at rd_addr (combinational) |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The checker assumes two things about the inputs:
- the host never issues a write strobe with an unknown offset;
- MISO is settled before each SCLK rising edge.

The bench's flash model only changes MISO half a system clock after it sees a rising SCLK, which leaves a full SCLK period before the next sample. The bench drives every host write away from the active edge. It waits for busy to clear before starting the next frame, except in the one scenario that deliberately writes during a frame.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_DATA   = 4;
  localparam int IDX_W    = 4;

  typedef struct packed {
    logic       valid;
    logic       has_addr;
    logic       has_dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT, SQ_END} seq_state_t;

  function automatic shape_t decode_mode(input logic [3:0] code);
    shape_t s;
    s = '0;
    s.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.n_wr = 3'd1;
      4'h3: s.n_rd = 3'd2;
      4'h4: s.has_addr = 1'b1;
      4'h5: begin s.has_addr = 1'b1; s.n_wr = 3'd1; end
      4'h6: begin s.has_addr = 1'b1; s.n_wr = 3'd4; end
      4'h7: begin s.has_addr = 1'b1; s.has_dummy = 1'b1; s.n_rd = 3'd4; end
      4'h8: begin s.has_addr = 1'b1; s.n_rd = 3'd1; end
      4'h9: begin s.has_addr = 1'b1; s.n_rd = 3'd2; end
      4'hA: begin s.has_addr = 1'b1; s.n_rd = 3'd3; end
      4'hB: begin s.has_addr = 1'b1; s.n_rd = 3'd4; end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [2:0]                    rd_addr,
  output logic [BYTE_W-1:0]             rd_data,
  input  logic                          busy,
  input  logic                          store_en,
  input  logic [1:0]                    store_idx,
  input  logic [BYTE_W-1:0]             store_data,
  output logic                          go,
  output logic [3:0]                    go_code,
  output logic [BYTE_W-1:0]             opcode,
  output logic [3:0]                    addr_top,
  output logic [BYTE_W-1:0]             addr_mid,
  output logic [BYTE_W-1:0]             addr_low,
  output logic [N_DATA-1:0][BYTE_W-1:0] data_q
);
  logic host_wr;
  shape_t req_shape;

  assign host_wr   = wr_en && !busy;
  assign go_code   = wr_data[7:4];
  assign req_shape = decode_mode(go_code);
  assign go        = host_wr && (wr_addr == 3'd1) && req_shape.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= '0;
      addr_top <= '0;
      addr_mid <= '0;
      addr_low <= '0;
      data_q   <= '0;
    end else begin
      if (host_wr) begin
        case (wr_addr)
          3'd0: opcode   <= wr_data;
          3'd1: if (go) addr_top <= wr_data[3:0];
          3'd2: addr_mid <= wr_data;
          3'd3: addr_low <= wr_data;
          default: data_q[wr_addr[1:0]] <= wr_data;
        endcase
      end
      if (store_en) data_q[store_idx] <= store_data;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = opcode;
      3'd1:    rd_data = {7'b0, busy};
      3'd2:    rd_data = addr_mid;
      3'd3:    rd_data = addr_low;
      default: rd_data = data_q[rd_addr[1:0]];
    endcase
  end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go,
  input  logic [3:0]                    go_code,
  input  logic [BYTE_W-1:0]             opcode,
  input  logic [3:0]                    addr_top,
  input  logic [BYTE_W-1:0]             addr_mid,
  input  logic [BYTE_W-1:0]             addr_low,
  input  logic [N_DATA-1:0][BYTE_W-1:0] data_q,
  input  logic                          byte_done,
  input  logic [BYTE_W-1:0]             rx_byte,
  output logic                          busy,
  output logic                          csn,
  output logic                          byte_start,
  output logic [BYTE_W-1:0]             tx_byte,
  output logic                          store_en,
  output logic [1:0]                    store_idx,
  output logic [BYTE_W-1:0]             store_data
);
  seq_state_t      state;
  shape_t          shp;
  logic [IDX_W-1:0] idx, hdr, last, slot;
  logic            in_data, is_read;

  assign hdr     = IDX_W'(1) + (shp.has_addr ? IDX_W'(3) : IDX_W'(0)) + IDX_W'(shp.has_dummy);
  assign last    = hdr + IDX_W'(shp.n_wr) + IDX_W'(shp.n_rd) - IDX_W'(1);
  assign slot    = idx - hdr;
  assign in_data = (idx >= hdr);
  assign is_read = in_data && (shp.n_rd != 3'd0);

  always_comb begin
    tx_byte = '0;
    if (idx == '0)                           tx_byte = opcode;
    else if (shp.has_addr && idx == IDX_W'(1)) tx_byte = {4'h0, addr_top};
    else if (shp.has_addr && idx == IDX_W'(2)) tx_byte = addr_mid;
    else if (shp.has_addr && idx == IDX_W'(3)) tx_byte = addr_low;
    else if (in_data && shp.n_wr != 3'd0)    tx_byte = data_q[slot[1:0]];
  end

  assign busy       = (state != SQ_IDLE);
  assign byte_start = (state == SQ_LOAD);
  assign store_en   = (state == SQ_WAIT) && byte_done && is_read;
  assign store_idx  = slot[1:0];
  assign store_data = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      shp   <= '0;
      idx   <= '0;
      csn   <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          shp   <= decode_mode(go_code);
          idx   <= '0;
          csn   <= 1'b0;
          state <= SQ_LOAD;
        end
        SQ_LOAD: state <= SQ_WAIT;
        SQ_WAIT: if (byte_done) begin
          if (idx == last) state <= SQ_END;
          else begin
            idx   <= idx + IDX_W'(1);
            state <= SQ_LOAD;
          end
        end
        default: begin
          csn   <= 1'b1;
          state <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sh     <= tx;
        cnt    <= '0;
        bitn   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (cnt == CW'(DIV_HALF - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       spi_sclk,
  output logic       spi_csn,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic                          busy, go, byte_start, byte_done, store_en;
  logic [3:0]                    go_code, addr_top;
  logic [1:0]                    store_idx;
  logic [BYTE_W-1:0]             opcode, addr_mid, addr_low, tx_byte, rx_byte, store_data;
  logic [N_DATA-1:0][BYTE_W-1:0] data_q;

  sfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .store_en(store_en), .store_idx(store_idx), .store_data(store_data),
    .go(go), .go_code(go_code), .opcode(opcode), .addr_top(addr_top),
    .addr_mid(addr_mid), .addr_low(addr_low), .data_q(data_q)
  );

  sfc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_code(go_code), .opcode(opcode),
    .addr_top(addr_top), .addr_mid(addr_mid), .addr_low(addr_low), .data_q(data_q),
    .byte_done(byte_done), .rx_byte(rx_byte), .busy(busy), .csn(spi_csn),
    .byte_start(byte_start), .tx_byte(tx_byte), .store_en(store_en),
    .store_idx(store_idx), .store_data(store_data)
  );

  sfc_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(byte_start), .tx(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(byte_done), .rx(rx_byte)
  );
endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk #(
  parameter int FRAME_LIMIT = 1250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       spi_sclk,
  input logic       spi_csn,
  input logic       spi_mosi
);
  logic [15:0] busy_cnt;
  logic        code_ok;

  assign code_ok = (wr_data[7:4] != 4'h0) && (wr_data[7:4] <= 4'hB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  AST_FRAME_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt < 16'(FRAME_LIMIT)); // R11

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk); // R9

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R9

  AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_csn |-> busy); // R10

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> $past(wr_en && wr_addr == 3'd1 && code_ok && !busy)); // R2

  AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && !code_ok && !busy && spi_csn) |=> spi_csn); // R3

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 3'd1) |=> !$fell(spi_csn)); // R10
endmodule

bind sfc_engine sfc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi)
);

// File: tb/sfc_engine_tb_top.sv
`timescale 1ns/1ps
module sfc_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       spi_sclk, spi_csn, spi_mosi, spi_miso;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] seed = 8'h00;
  logic [7:0] cap [0:15];
  int         nb = 0;
  int         last_len = 0;
  int         frames = 0;
  int         partial = 0;
  int         sclk_loose = 0;
  logic [2:0] bitcnt = '0;
  logic [7:0] shin = '0;
  logic       p_sclk = 1'b0;
  logic       p_csn = 1'b1;
  logic [7:0] cur_resp;

  always #4 clk = ~clk;

  sfc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(input logic [7:0] s, input int k);
    return s ^ 8'(k * 29 + 3);
  endfunction

  assign cur_resp = resp(seed, nb);
  assign spi_miso = cur_resp[3'd7 - bitcnt];

  // flash model: samples on detected SCLK rise, between clock edges
  always @(negedge clk) begin
    if (spi_csn && spi_sclk) sclk_loose++;
    if (!spi_csn && !p_sclk && spi_sclk) begin
      shin = {shin[6:0], spi_mosi};
      if (bitcnt == 3'd7) begin
        if (nb < 16) cap[nb] = shin;
        nb++;
        bitcnt = '0;
      end else bitcnt = bitcnt + 3'd1;
    end
    if (!p_csn && spi_csn) begin
      frames++;
      if (bitcnt != 3'd0) partial++;
      last_len = nb;
      nb = 0;
      bitcnt = '0;
    end
    p_sclk = spi_sclk;
    p_csn  = spi_csn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // expected frame shape, computed from the requirement text
  function automatic void shape(input int c, output bit ok, output int hdr,
                                output int nwr, output int nrd);
    ok  = (c >= 1 && c <= 11);
    hdr = 1 + ((c >= 4) ? 3 : 0) + ((c == 7) ? 1 : 0);
    nwr = (c == 2 || c == 5) ? 1 : (c == 6) ? 4 : 0;
    nrd = (c == 3) ? 2 : (c == 7) ? 4 : (c >= 8) ? c - 7 : 0;
    if (!ok) begin hdr = 0; nwr = 0; nrd = 0; end
  endfunction

  task automatic run_txn(input int c, input logic [3:0] nib, input logic [7:0] op,
                         input logic [7:0] a2, input logic [7:0] a3, input logic [7:0] base);
    bit ok; int hdr, nwr, nrd, f0, cyc, len;
    logic [7:0] v, e;
    logic [7:0] wd [0:3];
    shape(c, ok, hdr, nwr, nrd);
    len = hdr + nwr + nrd;
    for (int j = 0; j < 4; j++) wd[j] = base + 8'(j * 17);
    wr(3'd0, op); wr(3'd2, a2); wr(3'd3, a3);
    for (int j = 0; j < 4; j++) wr(3'(4 + j), wd[j]);
    f0 = frames;
    wr(3'd1, {4'(c), nib});
    if (!ok) begin
      repeat (200) @(negedge clk);
      check(frames == f0, "R3 frames", frames - f0, 0);
      rd(3'd1, v); check(v == 8'h00, "R3 status", v, 0);
      rd(3'd0, v); check(v == op, "R3 opcode kept", v, op);
      for (int j = 0; j < 4; j++) begin
        rd(3'(4 + j), v); check(v == wd[j], "R3 data kept", v, wd[j]);
      end
      return;
    end
    cyc = 1;
    rd(3'd1, v);
    check(v == 8'h01, "R10 busy after start", v, 1);
    while (v[0] && cyc < 3000) begin
      @(negedge clk); cyc++; rd(3'd1, v);
    end
    check(cyc <= 1250, "R11 frame time", cyc, 1250);
    repeat (3) @(negedge clk);
    check(frames == f0 + 1, "R2 one frame", frames - f0, 1);
    check(last_len == len, "R4/R5 length", last_len, len);
    for (int k = 0; k < len && k < 16; k++) begin
      if (k == 0) e = op;
      else if (hdr >= 4 && k == 1) e = {4'h0, nib};
      else if (hdr >= 4 && k == 2) e = a2;
      else if (hdr >= 4 && k == 3) e = a3;
      else if (k < hdr) e = 8'h00;
      else if (nwr != 0) e = wd[k - hdr];
      else e = 8'h00;
      if (c == 7) check(cap[k] == e, "R6 mosi byte", cap[k], e);
      else if (k >= hdr) check(cap[k] == e, "R7 mosi byte", cap[k], e);
      else check(cap[k] == e, "R5 mosi byte", cap[k], e);
    end
    for (int j = 0; j < 4; j++) begin
      e = (j < nrd) ? resp(seed, hdr + j) : wd[j];
      rd(3'(4 + j), v);
      check(v == e, "R8 data reg", v, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); check(v == 8'h00, "R1 reset value", v, 0);
    end
    check(spi_csn == 1'b1 && spi_sclk == 1'b0, "R1 reset pins", {spi_csn, spi_sclk}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    wr(3'd2, 8'h5C); rd(3'd2, v); check(v == 8'h5C, "R1 readback", v, 8'h5C);

    // sweep of all mode codes over three patterns
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) begin
        seed = 8'(8'h3A + p * 71 + c * 13);
        run_txn(c, 4'(c ^ (p * 5)), 8'(8'h90 + c + p * 16), 8'(8'h11 * (p + 1)),
                8'(8'hC3 - c), 8'(8'h40 + p * 40 + c));
      end
    end

    // R10: writes while busy are dropped
    seed = 8'h77;
    wr(3'd0, 8'h02); wr(3'd2, 8'hAB); wr(3'd3, 8'hCD);
    for (int j = 0; j < 4; j++) wr(3'(4 + j), 8'(8'hD0 + j));
    f0 = frames;
    wr(3'd1, 8'h6F);
    repeat (20) @(negedge clk);
    rd(3'd1, v); check(v == 8'h01, "R10 busy mid frame", v, 1);
    wr(3'd4, 8'hEE);
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h55);
    repeat (1300) @(negedge clk);
    check(frames == f0 + 1, "R10 single frame", frames - f0, 1);
    check(last_len == 8, "R10 length", last_len, 8);
    check(cap[4] == 8'hD0, "R10 data sent", cap[4], 8'hD0);
    rd(3'd4, v); check(v == 8'hD0, "R10 data reg kept", v, 8'hD0);
    rd(3'd0, v); check(v == 8'h02, "R10 opcode kept", v, 8'h02);
    check(partial == 0, "R9 whole bytes", partial, 0);
    check(sclk_loose == 0, "R9 sclk parked", sclk_loose, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule